// File: doc/BRIEF.md
# Seeded Memory CRC32 Engine

This block computes a CRC32 checksum over a word-aligned stretch of the flash array for a flash controller. Software first loads an initial value into the seed register. It then issues the run command together with a start byte address and a word count. The engine reads one 32-bit word per cycle through a read port with one cycle of latency and folds each word into the running CRC. While it runs, a read-only live register shows the CRC state after every word.

When the walk ends, the checksum stays in the engine. It is not returned until software issues the fetch-result command. That command copies the final CRC into the seed register, so the seed register serves both as the input to a calculation and as the place where its result is read. A request whose range does not cover whole pages is rejected with a one-cycle error pulse, and the engine does not start.

Top module: `crc_walk_engine`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, and both the seed register (offset 0x50) and the live register (offset 0x54) read 0.
- R2: Register writes at offset 0x50 set the seed register and read back unchanged. Writes at offset 0x54 have no effect. Every offset other than 0x50 and 0x54 reads 0.
- R3: A run command (`cmd` = 0x2D with `trig` high, engine idle, range valid) loads the live CRC state from the seed register. The live register shows the seed in the cycle after the trigger.
- R4: Each word is folded into the CRC using the reflected polynomial 0xEDB88320, processing bit 0 first, which is the same as processing the least significant byte first. No final XOR is applied. After the last word, the live register holds the CRC of the whole range.
- R5: A run of N words issues exactly N reads, one per cycle, at byte addresses start, start+4, and so on up to start+4(N-1). The first read is issued in the cycle after the trigger.
- R6: `busy` rises in the cycle after an accepted run trigger and stays high for N+2 cycles. It falls one cycle after the last word has been folded. `done` is high for exactly the cycle in which `busy` has just fallen.
- R7: While a run is in progress, the live register shows the CRC of the words folded so far, one more word per cycle, starting two cycles after the trigger.
- R8: A run request is rejected in three cases: the start address is not a multiple of the page size, the word count is not a whole number of pages, or the count is zero. On rejection, `err` pulses for one cycle after the trigger, `busy` stays low, no reads are issued, and both registers keep their values.
- R9: A fetch command (`cmd` = 0x0D with `trig` high, engine idle) copies the final CRC into the seed register and pulses `done`, both in the cycle after the trigger.
- R10: A trigger while `busy` is high is ignored, and so is a trigger with any command code other than 0x2D or 0x0D. Neither raises `busy`, `done` or `err`, issues a read, or changes a register.
- R11: Writing the seed register during a run does not change the CRC of that run. The written value remains readable until the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Command trigger strobe |
| cmd | input | 6 | Command code: 0x2D run, 0x0D fetch result |
| start_addr | input | ADDR_W | Start byte address of the range |
| word_count | input | CNT_W | Number of 32-bit words in the range |
| mem_rd_en | output | 1 | Word read request to the memory |
| mem_rd_addr | output | ADDR_W | Byte address of the requested word |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse for a run or a fetch |
| err | output | 1 | One-cycle pulse when a run request is rejected |
| reg_wr_en | input | 1 | Register write strobe |
| reg_offset | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_offset` |

## Verification
The embedded assertions check the following on every cycle:
- Reads happen only while busy, and consecutive reads step by exactly four bytes.
- Folds happen only while busy, and `busy` falls only together with `done`.
- `err` and `busy` are never high together.
- The live state equals the seed right after a start.
- The seed register holds its value unless it is written or loaded.
- A fetch copies the live CRC into the seed register.

Only the bench scenarios can show the rest: that the checksum values are correct, that each word lands in the live register in the right cycle, that the busy window has the right length, and that page validation works. The same goes for the claims that out-of-range triggers and seed writes during a run leave the running result untouched. The bench sweeps these over many start pages, lengths and seeds, and over every command code.

// File: rtl/crc_walk_pkg.sv
// Package crc_walk_pkg
// Shared constants, the state type and the word-wide CRC fold function for
// the seeded memory CRC32 engine. Assumes a reflected CRC-32 with no final
// XOR, applied to 32-bit words least significant bit first.
package crc_walk_pkg;

    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [5:0]  CMD_RUN   = 6'h2D;
    localparam logic [5:0]  CMD_FETCH = 6'h0D;
    localparam logic [7:0]  OFF_SEED  = 8'h50;
    localparam logic [7:0]  OFF_LIVE  = 8'h54;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } walk_state_e;

    // Fold one 32-bit word into the CRC state, bit 0 first.
    function automatic logic [31:0] crc_fold(input logic [31:0] state,
                                             input logic [31:0] word);
        logic [31:0] r;
        r = state ^ word;
        for (int i = 0; i < 32; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_walk_ctrl.sv
// Module crc_walk_ctrl
// Decodes the run and fetch commands, validates the requested range against
// page alignment, sequences the word reads and counts the folds. It assumes
// the memory returns data exactly one cycle after a read request, and that
// PAGE_BYTES is a power of two of at least 8.
module crc_walk_ctrl
    import crc_walk_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 12,
    parameter int PAGE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [5:0]        cmd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              fold_en,
    output logic              start_ok,
    output logic              load_result,
    output logic              busy,
    output logic              done,
    output logic              err
);

    localparam int PAGE_LSB      = $clog2(PAGE_BYTES);
    localparam int PAGE_WORD_LSB = PAGE_LSB - 2;

    walk_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  issue_left_q;
    logic [CNT_W-1:0]  fold_left_q;
    logic              rd_vld_q;
    logic              done_q;
    logic              err_q;
    logic              is_idle;
    logic              run_req;
    logic              fetch_req;
    logic              misaligned;
    logic              bad_len;
    logic              last_fold;

    // Decode the commands and check the range against whole pages.
    always_comb begin
        is_idle     = (state_q == ST_IDLE);
        run_req     = trig && (cmd == CMD_RUN) && is_idle;
        fetch_req   = trig && (cmd == CMD_FETCH) && is_idle;
        misaligned  = |start_addr[PAGE_LSB-1:0];
        bad_len     = (word_count == '0) || (|word_count[PAGE_WORD_LSB-1:0]);
        start_ok    = run_req && !misaligned && !bad_len;
        load_result = fetch_req;
        mem_rd_en   = (state_q == ST_RUN) && (issue_left_q != '0);
        mem_rd_addr = addr_q;
        fold_en     = rd_vld_q;
        last_fold   = rd_vld_q && (fold_left_q == CNT_W'(1));
        busy        = !is_idle;
        done        = done_q;
        err         = err_q;
    end

    // Walk state: idle, fetching and folding, then one drain cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start_ok)  state_q <= ST_RUN;
                ST_RUN:   if (last_fold) state_q <= ST_DRAIN;
                ST_DRAIN: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Address and word counters for issued reads and completed folds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q       <= '0;
            issue_left_q <= '0;
            fold_left_q  <= '0;
        end else if (start_ok) begin
            addr_q       <= start_addr;
            issue_left_q <= word_count;
            fold_left_q  <= word_count;
        end else begin
            if (mem_rd_en) begin
                addr_q       <= addr_q + ADDR_W'(4);
                issue_left_q <= issue_left_q - CNT_W'(1);
            end
            if (rd_vld_q) begin
                fold_left_q <= fold_left_q - CNT_W'(1);
            end
        end
    end

    // Read data valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_vld_q <= 1'b0;
        else        rd_vld_q <= mem_rd_en;
    end

    // Completion and rejection pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_DRAIN) || fetch_req;
            err_q  <= run_req && (misaligned || bad_len);
        end
    end

    assert_reads_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(4)));

    assert_fold_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fold_en |-> busy);

    assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_err_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

endmodule

// File: rtl/crc_walk_datapath.sv
// Module crc_walk_datapath
// Holds the live CRC state. It loads the seed on an accepted start and folds
// one memory word per cycle when the controller marks the data valid.
// It assumes start and fold are never requested in the same cycle.
module crc_walk_datapath
    import crc_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_ok,
    input  logic        fold_en,
    input  logic [31:0] seed,
    input  logic [31:0] word,
    output logic [31:0] live_crc
);

    logic [31:0] crc_q;

    // Seed on start, fold on every valid word.
    always_ff @(posedge clk) begin
        if (!rst_n)        crc_q <= '0;
        else if (start_ok) crc_q <= seed;
        else if (fold_en)  crc_q <= crc_fold(crc_q, word);
    end

    assign live_crc = crc_q;

    assert_seed_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_ok) |-> (crc_q == $past(seed)));

    assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_ok) && !$past(fold_en)) |-> $stable(crc_q));

endmodule

// File: rtl/crc_walk_regs.sv
// Module crc_walk_regs
// Software-visible seed register and read-only live register. A fetch
// command loads the live CRC into the seed register, and takes priority over
// a software write in the same cycle. Offsets other than the two registers
// read as zero.
module crc_walk_regs
    import crc_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_offset,
    input  logic [31:0] reg_wdata,
    input  logic        load_result,
    input  logic [31:0] live_crc,
    output logic [31:0] seed,
    output logic [31:0] reg_rdata
);

    logic [31:0] seed_q;
    logic        wr_seed;

    // Write decode: only the seed register accepts software writes.
    always_comb begin
        wr_seed = reg_wr_en && (reg_offset == OFF_SEED);
    end

    // Seed register: result load wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)           seed_q <= '0;
        else if (load_result) seed_q <= live_crc;
        else if (wr_seed)     seed_q <= reg_wdata;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_offset)
            OFF_SEED: reg_rdata = seed_q;
            OFF_LIVE: reg_rdata = live_crc;
            default:  reg_rdata = '0;
        endcase
    end

    assign seed = seed_q;

    assert_result_copied_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_result) |-> (seed_q == $past(live_crc)));

    assert_seed_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_result) && !$past(wr_seed)) |-> $stable(seed_q));

endmodule

// File: rtl/crc_walk_engine.sv
// Module crc_walk_engine
// Top of the seeded memory CRC32 engine: controller, CRC datapath and
// register file. It assumes a word memory with one cycle of read latency and
// word-aligned, page-granular ranges.
module crc_walk_engine
    import crc_walk_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 12,
    parameter int PAGE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [5:0]        cmd,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  word_count,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_offset,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic        start_ok;
    logic        fold_en;
    logic        load_result;
    logic [31:0] seed;
    logic [31:0] live_crc;

    crc_walk_ctrl #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .PAGE_BYTES(PAGE_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .cmd        (cmd),
        .start_addr (start_addr),
        .word_count (word_count),
        .mem_rd_en  (mem_rd_en),
        .mem_rd_addr(mem_rd_addr),
        .fold_en    (fold_en),
        .start_ok   (start_ok),
        .load_result(load_result),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );

    crc_walk_datapath u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ok(start_ok),
        .fold_en (fold_en),
        .seed    (seed),
        .word    (mem_rd_data),
        .live_crc(live_crc)
    );

    crc_walk_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_offset (reg_offset),
        .reg_wdata  (reg_wdata),
        .load_result(load_result),
        .live_crc   (live_crc),
        .seed       (seed),
        .reg_rdata  (reg_rdata)
    );

endmodule

// File: tb/crc_walk_engine_test.sv
module crc_walk_engine_test;

    localparam int AW = 10;
    localparam int CW = 8;
    localparam int PB = 16;
    localparam int PW = PB / 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          trig;
    logic [5:0]    cmd;
    logic [AW-1:0] start_addr;
    logic [CW-1:0] word_count;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [31:0]   mem_rd_data = '0;
    logic          busy, done, err;
    logic          reg_wr_en;
    logic [7:0]    reg_offset;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;

    int            total = 0;
    int            bad = 0;
    int            mon_cnt = 0;
    int            mon_bad = 0;
    logic [AW-1:0] mon_exp = '0;

    always #10 clk = ~clk;

    crc_walk_engine #(.ADDR_W(AW), .CNT_W(CW), .PAGE_BYTES(PB)) uut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .cmd(cmd),
        .start_addr(start_addr), .word_count(word_count),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .busy(busy), .done(done), .err(err),
        .reg_wr_en(reg_wr_en), .reg_offset(reg_offset), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] word_at(input int idx);
        logic [31:0] u;
        u = 32'(idx);
        return (u * 32'h9E3779B1) ^ 32'h5A5A0F0F ^ (u << 16);
    endfunction

    // Bytewise reflected CRC step, low byte first.
    function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 4; b++) begin
            r = r ^ ((w >> (8 * b)) & 32'hFF);
            for (int j = 0; j < 8; j++) begin
                if (r[0]) r = (r >> 1) ^ 32'hEDB88320;
                else      r = r >> 1;
            end
        end
        return r;
    endfunction

    // Memory model with one cycle of read latency, plus a read monitor.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            if (mem_rd_addr !== mon_exp) mon_bad = mon_bad + 1;
            mon_exp = mon_exp + AW'(4);
            mon_cnt = mon_cnt + 1;
            mem_rd_data <= word_at(int'(mem_rd_addr >> 2));
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [7:0] off, output logic [31:0] v);
        reg_offset = off;
        #1;
        v = reg_rdata;
    endtask

    task automatic write_reg(input logic [7:0] off, input logic [31:0] val);
        reg_wr_en  = 1'b1;
        reg_offset = off;
        reg_wdata  = val;
        @(negedge clk);
        reg_wr_en  = 1'b0;
    endtask

    task automatic pulse_cmd(input logic [5:0] code, input logic [AW-1:0] a,
                             input logic [CW-1:0] n);
        trig       = 1'b1;
        cmd        = code;
        start_addr = a;
        word_count = n;
        @(negedge clk);
        trig       = 1'b0;
    endtask

    task automatic run_case(input int a, input int n, input logic [31:0] seed,
                            input bit poke);
        logic [31:0] expc, fin, v;
        bit trace_ok, busy_ok;
        trace_ok = 1'b1;
        busy_ok  = 1'b1;
        write_reg(8'h50, seed);
        mon_cnt = 0;
        mon_bad = 0;
        mon_exp = AW'(a);
        fin = seed;
        for (int i = 0; i < n; i++) fin = ref_fold(fin, word_at(a / 4 + i));
        pulse_cmd(6'h2D, AW'(a), CW'(n));
        expc = seed;
        for (int k = 0; k <= n + 1; k++) begin
            if (poke && k == 2) begin
                trig = 1'b1; cmd = 6'h2D; start_addr = AW'(a ^ 64); word_count = CW'(PW);
            end
            if (poke && k == 3) begin
                trig = 1'b0; reg_wr_en = 1'b1; reg_offset = 8'h50; reg_wdata = ~seed;
            end
            if (poke && k == 4) reg_wr_en = 1'b0;
            if (k >= 2) expc = ref_fold(expc, word_at(a / 4 + k - 2));
            if (busy !== 1'b1 || done !== 1'b0) busy_ok = 1'b0;
            if (!(poke && k == 3)) begin
                read_reg(8'h54, v);
                if (v !== expc) begin
                    if (trace_ok) $display("trace mismatch at step %0d", k);
                    trace_ok = 1'b0;
                end
            end
            @(negedge clk);
        end
        check(busy_ok && busy === 1'b0, "R6 busy window", {31'd0, busy}, 32'd0);
        check(done === 1'b1, "R6 done at end", {31'd0, done}, 32'd1);
        check(trace_ok, "R7 R3 live trace", {31'd0, trace_ok}, 32'd1);
        read_reg(8'h54, v);
        check(v === fin, "R4 final crc", v, fin);
        check(mon_cnt == n && mon_bad == 0, "R5 R10 read sequence", 32'(mon_cnt), 32'(n));
        read_reg(8'h50, v);
        check(v === (poke ? ~seed : seed), "R11 seed after run", v, poke ? ~seed : seed);
        @(negedge clk);
        check(done === 1'b0, "R6 done single", {31'd0, done}, 32'd0);
        pulse_cmd(6'h0D, '0, '0);
        read_reg(8'h50, v);
        check(done === 1'b1 && v === fin, "R9 fetch result", v, fin);
        @(negedge clk);
    endtask

    task automatic err_case(input int a, input int n);
        logic [31:0] s0, c0, v;
        read_reg(8'h50, s0);
        read_reg(8'h54, c0);
        mon_cnt = 0;
        pulse_cmd(6'h2D, AW'(a), CW'(n));
        check(err === 1'b1 && busy === 1'b0, "R8 err pulse", {30'd0, err, busy}, 32'd2);
        @(negedge clk);
        check(err === 1'b0 && busy === 1'b0 && mon_cnt == 0, "R8 no start",
              32'(mon_cnt), 32'd0);
        read_reg(8'h50, v);
        check(v === s0, "R8 seed kept", v, s0);
        read_reg(8'h54, v);
        check(v === c0, "R8 live kept", v, c0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, c0;
        rst_n = 1'b0; trig = 1'b0; cmd = '0; start_addr = '0; word_count = '0;
        reg_wr_en = 1'b0; reg_offset = 8'h54; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1 flags",
              {29'd0, busy, done, err}, 32'd0);
        read_reg(8'h50, v);
        check(v === 32'd0, "R1 seed reset", v, 32'd0);
        read_reg(8'h54, v);
        check(v === 32'd0, "R1 live reset", v, 32'd0);

        // R2: register access
        write_reg(8'h50, 32'hC0FFEE11);
        read_reg(8'h50, v);
        check(v === 32'hC0FFEE11, "R2 seed readback", v, 32'hC0FFEE11);
        write_reg(8'h54, 32'h12345678);
        read_reg(8'h54, v);
        check(v === 32'd0, "R2 live read only", v, 32'd0);
        for (int o = 0; o < 256; o += 4) begin
            if (o != 8'h50 && o != 8'h54) begin
                read_reg(8'(o), v);
                check(v === 32'd0, "R2 unused offset", v, 32'd0);
            end
        end
        @(negedge clk);

        // R3 R4 R5 R6 R7 R9: sweep over start pages, lengths and seeds
        run_case(0, PW, 32'h0, 1'b0);
        run_case(16, PW, 32'hFFFFFFFF, 1'b0);
        for (int p = 0; p < 16; p++) begin
            for (int np = 1; np <= 4; np++) begin
                run_case(p * 48, np * PW, word_at(p * 7 + np) ^ 32'hA5A5A5A5,
                         (np >= 2) && (p % 5 == 0));
            end
        end

        // R8: rejected ranges
        for (int lo = 1; lo < PB; lo++) err_case(64 + lo, PW);
        err_case(32, 0);
        err_case(32, 1);
        err_case(32, 2);
        err_case(32, 3);
        err_case(32, PW + 1);
        err_case(4, 2 * PW + 2);

        // R10: every other command code has no effect
        for (int c = 0; c < 64; c++) begin
            if (c != 6'h2D && c != 6'h0D) begin
                read_reg(8'h54, c0);
                mon_cnt = 0;
                pulse_cmd(6'(c), '0, CW'(PW));
                check(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R10 code ignored",
                      32'(c), 32'd0);
                @(negedge clk);
                read_reg(8'h54, v);
                check(v === c0 && mon_cnt == 0 && busy === 1'b0 && done === 1'b0,
                      "R10 no side effect", v, c0);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule